// File: doc/BRIEF.md
# Generalized Bit Reverse Unit

This block applies a generalized reverse permutation to a 64-bit operand. The permutation is a cascade of six butterfly stages. Control bit k enables the stage that exchanges every adjacent pair of 2^k-bit blocks. The stages run in increasing order of k. Setting the low six control bits selects single-bit reversal, byte reversal, half swaps, or any of the 64 permutations in between.

The control value comes from one of two places, chosen by a select input: the low bits of a register operand, or a small immediate field. In word mode the control is cut to five bits. The two 32-bit halves are then permuted separately, so upper-half contents can never reach the low word. A record flag asks for a three-bit condition code computed from the signed result.

An input strobe launches one operation. The result, the output strobe and the condition code all appear one cycle later.

Top module: `grev_unit`

## Requirements
- R1: While reset is held and after it is released, `outValid` and `condValid` are 0, and `result` and `condOut` are all zeros, until a strobe is accepted.
- R2: With `useImm`=0 and `wordMode`=0, the control is `ctrlReg[5:0]`, and `ctrlReg[63:6]` has no effect. Result bit i equals source bit (i XOR control). For example, control 56 reverses the byte order.
- R3: With `useImm`=1, the control comes from `immCtl` (all six bits in doubleword mode), and `ctrlReg` is ignored.
- R4: With `wordMode`=1, only the low five control bits are used, from either source. No bit of `srcA[63:32]` reaches `result[31:0]`, and no bit of `srcA[31:0]` reaches `result[63:32]`.
- R5: A control value of zero returns the source unchanged.
- R6: A doubleword operation whose control has bit 5 clear gives the same result as a word-mode operation with the same low five control bits.
- R7: `result` and `outValid` update on the first rising edge after `inValid` is sampled high. `outValid` is a one-cycle pulse for each strobe. Without a strobe, `result` holds its value.
- R8: When `recordEn` is set, `condOut` is one-hot with bit 2 = negative, bit 1 = positive and bit 0 = zero, judged on the signed 64-bit result, and `condValid` pulses together with `outValid`. When `recordEn` is clear, `condOut` is 000 and `condValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| srcA | input | 64 | Source operand |
| ctrlReg | input | 64 | Register-sourced control value |
| immCtl | input | 6 | Immediate control field |
| useImm | input | 1 | 1 selects immCtl, 0 selects ctrlReg |
| wordMode | input | 1 | 1 limits control to five bits |
| recordEn | input | 1 | Request condition code |
| result | output | 64 | Permuted operand |
| outValid | output | 1 | Result strobe |
| condOut | output | 3 | {negative, positive, zero} condition code |
| condValid | output | 1 | Condition code strobe |

## Verification
Every result, the output strobe and the condition code are registered once. All of them are due on the first rising edge after the input strobe is sampled. The bench drives inputs on falling edges and holds the strobe for exactly one cycle. It then samples all outputs on the next falling edge, which lies half a cycle after that rising edge. One falling edge later it checks again that `outValid` has dropped and that `result` has not moved. This confirms both the single-cycle pulse and the hold behaviour.

// File: rtl/grev_pkg.sv
package grev_pkg;
  localparam int DATA_W = 64;
  localparam int CTL_W = $clog2(DATA_W);
  localparam int WORD_CTL_W = CTL_W - 1;

  typedef struct packed {
    logic             load;
    logic             record;
    logic             wordMode;
    logic [CTL_W-1:0] ctl;
  } grevStrobe_t;

  // Mask of bits whose index has bit k clear (lower member of each block pair)
  function automatic logic [DATA_W-1:0] lowMask(input int k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction
endpackage

// File: rtl/grev_ctrl.sv
module grev_ctrl
  import grev_pkg::*;
(
  input  logic              inValid,
  input  logic [DATA_W-1:0] ctrlReg,
  input  logic [CTL_W-1:0]  immCtl,
  input  logic              useImm,
  input  logic              wordMode,
  input  logic              recordEn,
  output grevStrobe_t       strobe
);
  logic [CTL_W-1:0] rawCtl;

  always_comb begin
    rawCtl = useImm ? immCtl : ctrlReg[CTL_W-1:0];
    strobe.load     = inValid;
    strobe.record   = recordEn;
    strobe.wordMode = wordMode;
    strobe.ctl      = rawCtl;
    if (wordMode) strobe.ctl[CTL_W-1] = 1'b0;
  end
endmodule

// File: rtl/grev_dp.sv
module grev_dp
  import grev_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] srcA,
  input  grevStrobe_t       strobe,
  output logic [DATA_W-1:0] result,
  output logic              outValid,
  output logic [2:0]        condOut,
  output logic              condValid
);
  logic [DATA_W-1:0] stageVal [CTL_W+1];
  logic [DATA_W-1:0] permVal;
  logic [2:0]        condNext;

  assign stageVal[0] = srcA;

  for (genvar k = 0; k < CTL_W; k++) begin : g_stage
    localparam int SHIFT = 1 << k;
    localparam logic [DATA_W-1:0] MASK = lowMask(k);
    logic [DATA_W-1:0] swapped;
    assign swapped = ((stageVal[k] & MASK) << SHIFT) |
                     ((stageVal[k] >> SHIFT) & MASK);
    assign stageVal[k+1] = strobe.ctl[k] ? swapped : stageVal[k];
  end

  assign permVal = stageVal[CTL_W];

  always_comb begin
    if (!strobe.record)               condNext = 3'b000;
    else if (permVal[DATA_W-1])       condNext = 3'b100;
    else if (permVal == '0)           condNext = 3'b001;
    else                              condNext = 3'b010;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      outValid  <= 1'b0;
      condOut   <= 3'b000;
      condValid <= 1'b0;
    end else begin
      outValid  <= strobe.load;
      condValid <= strobe.load & strobe.record;
      if (strobe.load) begin
        result  <= permVal;
        condOut <= condNext;
      end
    end
  end

  // R4
  word_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordMode |-> !strobe.ctl[CTL_W-1]);
  // R7
  out_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result) && !outValid);
  // R8
  cond_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    condValid |-> outValid && $onehot(condOut));
  // R8
  cond_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    condValid |-> (condOut[2] == result[DATA_W-1]) && (condOut[0] == (result == '0)));
endmodule

// File: rtl/grev_unit.sv
module grev_unit
  import grev_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] ctrlReg,
  input  logic [CTL_W-1:0]  immCtl,
  input  logic              useImm,
  input  logic              wordMode,
  input  logic              recordEn,
  output logic [DATA_W-1:0] result,
  output logic              outValid,
  output logic [2:0]        condOut,
  output logic              condValid
);
  grevStrobe_t strobe;

  grev_ctrl u_ctrl (
    .inValid(inValid), .ctrlReg(ctrlReg), .immCtl(immCtl), .useImm(useImm),
    .wordMode(wordMode), .recordEn(recordEn), .strobe(strobe)
  );

  grev_dp u_dp (
    .clk(clk), .rstN(rstN), .srcA(srcA), .strobe(strobe), .result(result),
    .outValid(outValid), .condOut(condOut), .condValid(condValid)
  );
endmodule

// File: tb/sim_grev_unit.sv
module sim_grev_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] ctrlReg = '0;
  logic [5:0]  immCtl = '0;
  logic        useImm = 1'b0;
  logic        wordMode = 1'b0;
  logic        recordEn = 1'b0;
  logic [63:0] result;
  logic        outValid;
  logic [2:0]  condOut;
  logic        condValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  grev_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .ctrlReg(ctrlReg),
    .immCtl(immCtl), .useImm(useImm), .wordMode(wordMode), .recordEn(recordEn),
    .result(result), .outValid(outValid), .condOut(condOut), .condValid(condValid)
  );

  localparam int NVEC = 8;
  localparam logic [63:0] VSRC [NVEC] = '{
    64'h0102030405060708, 64'h0102030405060708, 64'h0102030405060708,
    64'h0000000000000001, 64'hFFFFFFFF00000000, 64'hDEADBEEF12345678,
    64'h0000000000000001, 64'h0000000000000012};
  localparam logic [63:0] VREG [NVEC] = '{
    64'd56, 64'hFFFFFFFFFFFFFFE0, 64'hFFFF, 64'hFFFFFFFFFFFFFF3F,
    64'd0, 64'hFFFFFFFFFFFFFFC0, 64'd63, 64'd4};
  localparam logic [5:0]  VIMM [NVEC] = '{6'd0, 6'd0, 6'd8, 6'd0, 6'd63, 6'd0, 6'd0, 6'd0};
  localparam logic        VUSEIMM [NVEC] = '{0, 0, 1, 0, 1, 0, 0, 0};
  localparam logic        VWORD [NVEC] = '{0, 0, 0, 1, 1, 0, 0, 0};
  localparam logic [63:0] VEXP [NVEC] = '{
    64'h0807060504030201, 64'h0506070801020304, 64'h0201040306050807,
    64'h0000000080000000, 64'hFFFFFFFF00000000, 64'hDEADBEEF12345678,
    64'h8000000000000000, 64'h0000000000000021};
  localparam string VTAG [NVEC] = '{"R2", "R2", "R3", "R4", "R4", "R5", "R2", "R2"};

  // Reference: bit i of the result is source bit (i XOR control)
  function automatic logic [63:0] refGrev(input logic [63:0] s, input logic [5:0] c);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = s[i ^ int'(c)];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] s, input logic [63:0] r, input logic [5:0] im,
                       input logic ui, input logic wm, input logic rec);
    @(negedge clk);
    srcA = s; ctrlReg = r; immCtl = im; useImm = ui; wordMode = wm; recordEn = rec;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    logic [63:0] dwRes;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result", result, 64'd0);
    check("R1 strobes", {61'd0, outValid, condValid, |condOut}, 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      apply(VSRC[v], VREG[v], VIMM[v], VUSEIMM[v], VWORD[v], 1'b0);
      check(VTAG[v], result, VEXP[v]);
      check("R7 outValid due", {63'd0, outValid}, 64'd1);
    end

    // R7 single-cycle pulse and hold
    held = result;
    @(negedge clk);
    check("R7 pulse ends", {63'd0, outValid}, 64'd0);
    srcA = 64'h1234; ctrlReg = 64'd7;
    repeat (2) @(negedge clk);
    check("R7 result held", result, held);

    // R2 sweep of all doubleword controls against the reference
    for (int c = 0; c < 64; c++) begin
      apply(64'hA5C3_0F1E_7788_9911 ^ (64'd1 << c), 64'(c), 6'd0, 1'b0, 1'b0, 1'b0);
      check("R2 sweep", result, refGrev(64'hA5C3_0F1E_7788_9911 ^ (64'd1 << c), 6'(c)));
    end

    // R3 immediate ignores register control
    apply(64'h0123456789ABCDEF, 64'd63, 6'd32, 1'b1, 1'b0, 1'b0);
    check("R3 imm select", result, 64'h89ABCDEF01234567);

    // R4 no crossing of halves in word mode
    apply(64'hFFFFFFFF00000000, 64'd63, 6'd0, 1'b0, 1'b1, 1'b0);
    check("R4 low half clean", {32'd0, result[31:0]}, 64'd0);
    apply(64'h00000000FFFFFFFF, 64'd0, 6'd63, 1'b1, 1'b1, 1'b0);
    check("R4 high half clean", {32'd0, result[63:32]}, 64'd0);

    // R6 bit5 clear in doubleword equals word mode
    apply(64'h13579BDF2468ACE0, 64'd27, 6'd0, 1'b0, 1'b0, 1'b0);
    dwRes = result;
    apply(64'h13579BDF2468ACE0, 64'd59, 6'd0, 1'b0, 1'b1, 1'b0);
    check("R6 dword vs word", result, dwRes);
    check("R6 reference", dwRes, refGrev(64'h13579BDF2468ACE0, 6'd27));

    // R8 condition codes
    apply(64'd1, 64'd63, 6'd0, 1'b0, 1'b0, 1'b1);
    check("R8 negative", {60'd0, condValid, condOut}, 64'h0C);
    apply(64'd0, 64'd21, 6'd0, 1'b0, 1'b0, 1'b1);
    check("R8 zero", {60'd0, condValid, condOut}, 64'h09);
    apply(64'h0000000000000080, 64'd0, 6'd1, 1'b1, 1'b0, 1'b1);
    check("R8 positive", {60'd0, condValid, condOut}, 64'h0A);
    @(negedge clk);
    check("R8 condValid pulse", {63'd0, condValid}, 64'd0);
    apply(64'd1, 64'd63, 6'd0, 1'b0, 1'b0, 1'b0);
    check("R8 no record", {60'd0, condValid, condOut}, 64'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule